// File: doc/BRIEF.md
# Sticky Error Status Capture

This block keeps a copy of a wide status word for debug. Each status word arrives on a valid/ready stream. While no error has been seen, every accepted word overwrites the copy. When an accepted word has its error flag set, the block keeps that word and enters a held state. Later words are then dropped until software releases the hold. Software reads the copy as a bank of 32-bit registers through a plain index-addressed read port.

Software releases the hold by writing a 1 into bit 0 at index 0 of the write port. The block then resumes tracking the stream. A `sticky` output shows the held state for test.

The stream never back-pressures. `stat_ready` is high at all times, so every cycle with `stat_valid` high is a transfer. The sender may present a new word on any cycle, and a word offered while the block is held is consumed and discarded. Decoding the status fields other than the error flag is outside this block.

Top module: `sticky_status_capture`

## Requirements
- R1: `stat_ready` is 1 in every cycle, so each cycle with `stat_valid` high transfers one word.
- R2: While the block is not held, an accepted word replaces the copy. Register index k returns status bits [32k+31:32k] on `rd_data` from the cycle after the transfer. A cycle with `stat_valid` low leaves the copy unchanged.
- R3: An accepted word whose bit ERR_BIT is 1 (default ERR_BIT = 159, which is bit 31 of index 4) is kept. Every later word is discarded while the block is held.
- R4: `sticky` goes to 1 in the cycle after an erroring word is accepted. It stays at 1 until a release takes effect.
- R5: A write with `wr_en`=1, `wr_addr`=0 and `wr_data[0]`=1 clears `sticky` at the next edge. The next valid word is then captured.
- R6: A write to any index other than 0, or a write to index 0 with `wr_data[0]`=0, changes neither `sticky` nor the copy.
- R7: If a release and an accepted word arrive in the same cycle, the word is captured. `sticky` then takes that word's error bit: it stays 1 for an erroring word and clears for a clean one.
- R8: After reset, all five registers read 0 and `sticky` is 0.
- R9: A read index of 5 or above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_valid | input | 1 | Status word present |
| stat_ready | output | 1 | Always 1; the block never stalls |
| stat_data | input | 160 | Status word |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data; bit 0 at index 0 releases the hold |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 32 | Selected captured register, combinational |
| sticky | output | 1 | High while a captured error is held |

## Verification
The assertions take for granted that `stat_data` and the write-port inputs carry known values in every cycle in which their strobes are high. They also assume `stat_valid` and `wr_en` are never unknown after reset. The bench drives all inputs from tasks on the falling edge and returns both strobes to 0 right after each rising edge, so no strobe stays high longer than one cycle. It places every release either on its own or in the same cycle as a chosen clean or erroring word, which covers both sides of R7.

// File: rtl/sscap_pkg.sv
package sscap_pkg;
  typedef enum logic {
    CAP_TRACK = 1'b0,
    CAP_HELD  = 1'b1
  } cap_state_e;

  localparam int unsigned DEF_WORD_W    = 32;
  localparam int unsigned DEF_NUM_WORDS = 5;
endpackage

// File: rtl/sscap_release_decode.sv
module sscap_release_decode #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              release_o
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data_i[WORD_W-1:1];

  // Only a 1 written into bit 0 of index 0 counts as a release.
  assign release_o = wr_en_i && (wr_addr_i == '0) && wr_data_i[0];
endmodule

// File: rtl/sscap_core.sv
module sscap_core
  import sscap_pkg::*;
#(
  parameter int unsigned STAT_W  = 160,
  parameter int unsigned ERR_BIT = 159
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [STAT_W-1:0] data_i,
  input  logic              release_i,
  output logic [STAT_W-1:0] cap_o,
  output logic              held_o
);
  cap_state_e        state_q;
  logic [STAT_W-1:0] cap_q;
  logic              load;

  // Load when tracking, or when a release opens the hold in this very cycle.
  assign load = take_i && ((state_q == CAP_TRACK) || release_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      state_q <= CAP_TRACK;
    end else if (load) begin
      cap_q   <= data_i;
      state_q <= data_i[ERR_BIT] ? CAP_HELD : CAP_TRACK;
    end else if (release_i) begin
      state_q <= CAP_TRACK;
    end
  end

  assign cap_o  = cap_q;
  assign held_o = (state_q == CAP_HELD);

  assert_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !held_o) |=> (cap_o == $past(data_i)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o && !release_i) |=> $stable(cap_o));

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && (!held_o || release_i) && data_i[ERR_BIT]) |=> held_o);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !(take_i && data_i[ERR_BIT])) |=> !held_o);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i) |=> $stable(cap_o));
endmodule

// File: rtl/sscap_read_mux.sv
module sscap_read_mux #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [WORD_W*NUM_WORDS-1:0] cap_i,
  input  logic [IDX_W-1:0]            rd_addr_i,
  output logic [WORD_W-1:0]           rd_data_o
);
  localparam int unsigned SLOTS = 1 << IDX_W;

  logic [WORD_W-1:0] bank [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_WORDS) begin : g_live
      assign bank[g] = cap_i[g*WORD_W +: WORD_W];
    end else begin : g_empty
      assign bank[g] = '0;
    end
  end

  assign rd_data_o = bank[rd_addr_i];

  always_comb begin
    if (32'(rd_addr_i) >= NUM_WORDS)
      assert_oob_R9: assert (rd_data_o == '0);
  end
endmodule

// File: rtl/sticky_status_capture.sv
module sticky_status_capture
  import sscap_pkg::*;
#(
  parameter int unsigned WORD_W    = DEF_WORD_W,
  parameter int unsigned NUM_WORDS = DEF_NUM_WORDS,
  parameter int unsigned ERR_BIT   = WORD_W*NUM_WORDS-1,
  localparam int unsigned STAT_W   = WORD_W*NUM_WORDS,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_valid,
  output logic              stat_ready,
  input  logic [STAT_W-1:0] stat_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              sticky
);
  logic              rel;
  logic [STAT_W-1:0] cap;

  assign stat_ready = 1'b1;

  sscap_release_decode #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_rel (
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .release_o (rel)
  );

  sscap_core #(.STAT_W(STAT_W), .ERR_BIT(ERR_BIT)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (stat_valid && stat_ready),
    .data_i    (stat_data),
    .release_i (rel),
    .cap_o     (cap),
    .held_o    (sticky)
  );

  sscap_read_mux #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_mux (
    .cap_i     (cap),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  assert_noop_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rel && !stat_valid) |=> ($stable(sticky) && $stable(cap)));
endmodule

// File: tb/tb_sticky_status_capture.sv
`timescale 1ns/100ps
module tb_sticky_status_capture;
  localparam int ERR = 159;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stat_valid = 1'b0;
  logic         stat_ready;
  logic [159:0] stat_data = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         sticky;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [159:0] exp_data_q [$];
  bit           exp_stk_q  [$];
  string        exp_tag_q  [$];

  logic [159:0] m_cap = '0;
  bit           m_stk = 0;

  always #2.5 clk = ~clk;

  sticky_status_capture dut (
    .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid), .stat_ready(stat_ready),
    .stat_data(stat_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sticky(sticky)
  );

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [159:0] mkword(bit err);
    logic [159:0] w;
    for (int i = 0; i < 5; i++) w[i*32 +: 32] = $urandom;
    w[ERR] = err;
    return w;
  endfunction

  // Driver: one cycle of stimulus, model update, push of the expected state.
  task automatic step(bit v, logic [159:0] d, bit we, logic [2:0] wa,
                      logic [31:0] wd, string tag);
    bit rel;
    @(negedge clk);
    stat_valid = v; stat_data = d; wr_en = we; wr_addr = wa; wr_data = wd;
    rel = we && (wa == 3'd0) && wd[0];
    if (v && (!m_stk || rel)) begin
      m_cap = d;
      m_stk = d[ERR];
    end else if (rel) begin
      m_stk = 0;
    end
    @(posedge clk);
    #0.1;
    stat_valid = 1'b0; wr_en = 1'b0;
    exp_data_q.push_back(m_cap);
    exp_stk_q.push_back(m_stk);
    exp_tag_q.push_back(tag);
  endtask

  // Monitor: pops expected items and reads back all five registers.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_data_q.size() > 0) begin
        logic [159:0] ed;
        bit es;
        string t;
        ed = exp_data_q.pop_front();
        es = exp_stk_q.pop_front();
        t  = exp_tag_q.pop_front();
        for (int k = 0; k < 5; k++) begin
          rd_addr = 3'(k);
          #0.1;
          check32($sformatf("%s word%0d", t, k), rd_data, ed[k*32 +: 32]);
        end
        check32({t, " R4 sticky"}, {31'd0, sticky}, {31'd0, es});
        check32("R1 ready", {31'd0, stat_ready}, 32'd1);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [159:0] e1;
    logic [159:0] e2;
    repeat (3) @(posedge clk);
    #0.1 rst_n = 1'b1;
    step(0, '0, 0, 0, 0, "R8 reset");
    // R2: tracking while not held
    step(1, mkword(0), 0, 0, 0, "R2 load a");
    step(1, mkword(0), 0, 0, 0, "R2 load b");
    step(0, mkword(0), 0, 0, 0, "R2 idle");
    step(1, mkword(0), 0, 0, 0, "R2 load c");
    // R3: error word retained, later words dropped
    e1 = mkword(1);
    step(1, e1, 0, 0, 0, "R3 err capture");
    step(1, mkword(0), 0, 0, 0, "R3 drop clean");
    step(1, mkword(1), 0, 0, 0, "R3 drop err");
    // R6: writes that do not release
    step(0, '0, 1, 3'd2, 32'h1, "R6 other index");
    step(0, '0, 1, 3'd0, 32'hFFFF_FFFE, "R6 bit0 clear");
    // R5: release, then capture resumes
    step(0, '0, 1, 3'd0, 32'h1, "R5 release");
    step(1, mkword(0), 0, 0, 0, "R5 resume");
    // R7: release together with a new word
    e2 = mkword(1);
    step(1, e2, 0, 0, 0, "R7 hold");
    step(1, mkword(1), 1, 3'd0, 32'h1, "R7 rel+err");
    step(1, mkword(0), 1, 3'd0, 32'h1, "R7 rel+clean");
    step(1, mkword(0), 0, 0, 0, "R7 tracking again");
    wait (exp_data_q.size() == 0);
    @(negedge clk);
    #1;
    // R9: indices beyond the bank read zero
    for (int a = 5; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.1;
      check32($sformatf("R9 index %0d", a), rd_data, 32'd0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule